// File: doc/BRIEF.md
# Lockstep Compare and Checkpoint Recovery Controller

This controller sits beside two mirrored copies of an instruction/execution pipeline. Each cycle the copies present their result (instruction address, destination register index and write data) at the stage before the last one. The controller compares the two results there and registers the outcome into the final stage, so checking costs no extra pipeline cycles. When the copies agree, the final stage retires the result: `commit_en` is raised and the register value and instruction address are written into a checkpoint store that only this block owns.

When the copies disagree, the failing result is dropped and a recovery sequence starts. First the pipelines are reset; the checkpoint store is left untouched. Next a cache and directory purge is requested, and the controller waits for it to finish. The last good state is then replayed, one register per cycle, on a restore bus, and finally a retry pulse is issued. A mismatch that arrives while a recovery is running is ignored.

Two counters separate recurring faults from one-off ones:
- **Consecutive-failure counter.** It counts mismatches that follow one another within a configurable window. When it reaches a limit, the block requests a spare unit and stops for good.
- **Decaying error counter.** It rises on each mismatch and falls once per configurable number of error-free commits. It raises an intermittent-fault flag while it sits at or above a threshold.

The pipelines, the cache and the sparing action outside the block are seen only as handshake signals.

Top module: `lockstep_recovery_ctrl`

## Requirements
- R1: A valid result whose two copies match in address, register index and data, presented while the controller is idle, raises `commit_en` for exactly the following cycle, and its data and address become the checkpointed state.
- R2: A valid result whose copies differ in any field is never committed. `pipe_rst` is then high for exactly one cycle, two clock edges after the result was presented.
- R3: In the cycle after `pipe_rst`, `purge_req` rises. It stays high until the cycle in which `purge_done` is sampled high.
- R4: After the purge, the restore bus carries NREGS beats on consecutive cycles with `restore_idx` running 0 to NREGS-1. Each beat shows the checkpointed value of that register and, on `restore_pc`, the address of the last committed instruction.
- R5: One cycle after the last restore beat, `retry_pulse` is high for one cycle. The controller is then idle and accepts commits again.
- R6: Valid results presented while a recovery is in progress, matching or not, are ignored. They neither commit nor start a further recovery, and they do not change either error counter.
- R7: A mismatch that comes fewer than `cfg_retry_window` cycles after the previous accepted mismatch increments the consecutive-failure count; any other mismatch sets it to 1. When the count reaches `cfg_fail_limit`, the controller instead enters a terminal halt: `spare_req` and `pipe_rst` stay high until reset, and no restore, retry or commit follows.
- R8: Each accepted mismatch increments a saturating error count and clears an error-free commit tally. Every `cfg_decay_period` error-free commits decrement the count by one, down to zero. `intermittent_flag` is high exactly while the count is at least `cfg_intermit_thresh`.
- R9: After a synchronous active-low reset, all outputs are low, the checkpoint registers and address read as zero, and both counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fail_limit | input | CNT_W | Consecutive failures that escalate to a spare request |
| cfg_retry_window | input | CNT_W | Cycles after a mismatch during which a new mismatch counts as consecutive |
| cfg_decay_period | input | CNT_W | Error-free commits per error-count decrement |
| cfg_intermit_thresh | input | CNT_W | Error count at which the intermittent flag rises |
| cmp_valid | input | 1 | Both copies present a result at the compare stage |
| a_pc | input | PC_W | Copy A instruction address |
| a_wreg | input | IDX_W | Copy A destination register |
| a_wdata | input | DATA_W | Copy A write data |
| b_pc | input | PC_W | Copy B instruction address |
| b_wreg | input | IDX_W | Copy B destination register |
| b_wdata | input | DATA_W | Copy B write data |
| purge_done | input | 1 | Cache and directory purge finished |
| commit_en | output | 1 | Final stage retires the compared result |
| pipe_rst | output | 1 | Reset both pipeline copies |
| purge_req | output | 1 | Request cache and directory purge |
| restore_valid | output | 1 | Restore beat present |
| restore_idx | output | IDX_W | Register being restored |
| restore_data | output | DATA_W | Checkpointed register value |
| restore_pc | output | PC_W | Checkpointed instruction address |
| retry_pulse | output | 1 | Restart execution from the restored state |
| spare_req | output | 1 | Request activation of a spare unit (terminal) |
| intermittent_flag | output | 1 | Error count at or above threshold |

## Verification
The bench corrupts a result that writes a register holding an older checkpointed value. A design that committed the failing result would replay the new value during restore. Mismatches are also injected while a purge is pending: a controller that accepted them would run a second recovery, or would hold the intermittent flag high after the decay commits. Mismatches are placed both inside and outside the retry window, so that a wrong window comparison either halts too early or never reaches the spare request. The purge handshake is held off for several cycles to catch a request that drops before `purge_done`.

// File: rtl/lsr_pkg.sv
// Package: shared types of the lockstep recovery controller.
// Assumes: nothing beyond IEEE 1800-2017.
package lsr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET,
        ST_PURGE,
        ST_RESTORE,
        ST_RETRY,
        ST_HALT
    } rec_state_e;

endpackage

// File: rtl/lsr_compare.sv
// lsr_compare: registers the comparison of the two copies into the final stage.
// Assumes: 'accept' is high only while the sequencer is idle; results arriving
// while a mismatch sits in the final stage are dropped, so nothing behind a
// failing instruction can retire.
module lsr_compare #(
    parameter int PC_W   = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              cmp_valid,
    input  logic [PC_W-1:0]   a_pc,
    input  logic [IDX_W-1:0]  a_wreg,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic [PC_W-1:0]   b_pc,
    input  logic [IDX_W-1:0]  b_wreg,
    input  logic [DATA_W-1:0] b_wdata,
    output logic              fin_commit,
    output logic              fin_mis,
    output logic [PC_W-1:0]   fin_pc,
    output logic [IDX_W-1:0]  fin_wreg,
    output logic [DATA_W-1:0] fin_wdata
);

    logic same;
    logic take;

    // Purpose: decide agreement and whether this result may enter the final stage.
    always_comb begin
        same = (a_pc == b_pc) && (a_wreg == b_wreg) && (a_wdata == b_wdata);
        take = cmp_valid && accept && !fin_mis;
    end

    // Purpose: final-stage register holding the verdict and the copy-A result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fin_commit <= 1'b0;
            fin_mis    <= 1'b0;
            fin_pc     <= '0;
            fin_wreg   <= '0;
            fin_wdata  <= '0;
        end else begin
            fin_commit <= take && same;
            fin_mis    <= take && !same;
            fin_pc     <= a_pc;
            fin_wreg   <= a_wreg;
            fin_wdata  <= a_wdata;
        end
    end

    // R2
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fin_commit && fin_mis));

    // R2
    no_back_to_back_mis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_mis |=> !fin_mis && !fin_commit);

endmodule

// File: rtl/lsr_ckpt_store.sv
// lsr_ckpt_store: protected checkpoint of the register file and instruction address.
// Assumes: written only by final-stage commits; never cleared by the pipeline reset.
module lsr_ckpt_store #(
    parameter int PC_W   = 16,
    parameter int DATA_W = 32,
    parameter int NREGS  = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PC_W-1:0]   wr_pc,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [PC_W-1:0]   ckpt_pc
);

    logic [DATA_W-1:0] regs [NREGS];

    // Purpose: one register per architectural entry, each with its own write decode.
    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                regs[g] <= wr_data;
        end
    end

    // Purpose: checkpointed address of the last retired instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ckpt_pc <= '0;
        else if (wr_en)
            ckpt_pc <= wr_pc;
    end

    // Purpose: asynchronous read port for the restore bus.
    always_comb rd_data = regs[rd_idx];

    // R1
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ckpt_pc));

endmodule

// File: rtl/lsr_err_track.sv
// lsr_err_track: consecutive-failure and decaying error accounting.
// Assumes: 'mis' pulses once per accepted mismatch and 'commit' once per retired
// result; the two never coincide.
module lsr_err_track #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mis,
    input  logic             commit,
    input  logic [CNT_W-1:0] cfg_fail_limit,
    input  logic [CNT_W-1:0] cfg_retry_window,
    input  logic [CNT_W-1:0] cfg_decay_period,
    input  logic [CNT_W-1:0] cfg_intermit_thresh,
    output logic             escalate,
    output logic             intermittent_flag
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             seen;
    logic [CNT_W-1:0] since;
    logic [CNT_W-1:0] consec;
    logic [CNT_W-1:0] consec_nxt;
    logic [CNT_W-1:0] err_cnt;
    logic [CNT_W-1:0] ok_cnt;
    logic [CNT_W-1:0] ok_inc;

    // Purpose: consecutive count this mismatch would produce and its escalation.
    always_comb begin
        if (seen && (since < cfg_retry_window))
            consec_nxt = (consec == CNT_MAX) ? consec : consec + 1'b1;
        else
            consec_nxt = CNT_W'(1);
        escalate = (consec_nxt >= cfg_fail_limit);
        ok_inc   = ok_cnt + 1'b1;
    end

    // Purpose: cycles since the last accepted mismatch, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen  <= 1'b0;
            since <= '0;
        end else if (mis) begin
            seen  <= 1'b1;
            since <= '0;
        end else if (since != CNT_MAX) begin
            since <= since + 1'b1;
        end
    end

    // Purpose: consecutive-failure count, updated on each accepted mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            consec <= '0;
        else if (mis)
            consec <= consec_nxt;
    end

    // Purpose: decaying error count and the error-free commit tally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_cnt <= '0;
            ok_cnt  <= '0;
        end else if (mis) begin
            ok_cnt  <= '0;
            if (err_cnt != CNT_MAX)
                err_cnt <= err_cnt + 1'b1;
        end else if (commit && (cfg_decay_period != '0)) begin
            if (ok_inc >= cfg_decay_period) begin
                ok_cnt <= '0;
                if (err_cnt != '0)
                    err_cnt <= err_cnt - 1'b1;
            end else begin
                ok_cnt <= ok_inc;
            end
        end
    end

    // Purpose: threshold comparison for the intermittent-fault indication.
    always_comb intermittent_flag = (err_cnt >= cfg_intermit_thresh) && (cfg_intermit_thresh != '0);

    // R8
    err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mis && !commit |=> $stable(err_cnt));

    // R8
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mis && (err_cnt != CNT_MAX) |=> err_cnt == $past(err_cnt) + 1'b1);

    // R7
    consec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mis |=> $stable(consec));

endmodule

// File: rtl/lsr_sequencer.sv
// lsr_sequencer: recovery state machine (reset, purge, restore, retry, halt).
// Assumes: 'mis' is only raised while idle; 'escalate' is valid with 'mis'.
module lsr_sequencer #(
    parameter int NREGS = 8,
    parameter int IDX_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mis,
    input  logic                  escalate,
    input  logic                  purge_done,
    output lsr_pkg::rec_state_e   state,
    output logic [IDX_W-1:0]      restore_idx,
    output logic                  pipe_rst,
    output logic                  purge_req,
    output logic                  restore_valid,
    output logic                  retry_pulse,
    output logic                  spare_req
);
    import lsr_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREGS - 1);

    // Purpose: state transitions and restore index stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            restore_idx <= '0;
        end else begin
            case (state)
                ST_IDLE:    if (mis) state <= escalate ? ST_HALT : ST_RESET;
                ST_RESET:   state <= ST_PURGE;
                ST_PURGE:   if (purge_done) begin
                                state       <= ST_RESTORE;
                                restore_idx <= '0;
                            end
                ST_RESTORE: if (restore_idx == LAST_IDX) state <= ST_RETRY;
                            else restore_idx <= restore_idx + 1'b1;
                ST_RETRY:   state <= ST_IDLE;
                ST_HALT:    state <= ST_HALT;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: decode handshake outputs from the current state.
    always_comb begin
        pipe_rst      = (state == ST_RESET) || (state == ST_HALT);
        purge_req     = (state == ST_PURGE);
        restore_valid = (state == ST_RESTORE);
        retry_pulse   = (state == ST_RETRY);
        spare_req     = (state == ST_HALT);
    end

    // R3
    purge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        purge_req && !purge_done |=> purge_req);

    // R4
    restore_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_valid && (restore_idx != LAST_IDX) |=> restore_valid && (restore_idx == $past(restore_idx) + 1'b1));

    // R5
    retry_after_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_valid && (restore_idx == LAST_IDX) |=> retry_pulse);

    // R7
    spare_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spare_req |=> spare_req && pipe_rst);

    // R2
    reset_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pipe_rst) && !spare_req |=> !pipe_rst && purge_req);

    // R6
    phases_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pipe_rst, purge_req, restore_valid, retry_pulse}));

endmodule

// File: rtl/lockstep_recovery_ctrl.sv
// lockstep_recovery_ctrl: compares two mirrored pipelines before commit,
// checkpoints agreed results and sequences recovery on disagreement.
// Assumes: both copies present results in the same cycle; the purge handshake
// and spare activation are serviced outside.
module lockstep_recovery_ctrl #(
    parameter int PC_W   = 16,
    parameter int DATA_W = 32,
    parameter int NREGS  = 8,
    parameter int CNT_W  = 8,
    localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_fail_limit,
    input  logic [CNT_W-1:0]  cfg_retry_window,
    input  logic [CNT_W-1:0]  cfg_decay_period,
    input  logic [CNT_W-1:0]  cfg_intermit_thresh,
    input  logic              cmp_valid,
    input  logic [PC_W-1:0]   a_pc,
    input  logic [IDX_W-1:0]  a_wreg,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic [PC_W-1:0]   b_pc,
    input  logic [IDX_W-1:0]  b_wreg,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic              purge_done,
    output logic              commit_en,
    output logic              pipe_rst,
    output logic              purge_req,
    output logic              restore_valid,
    output logic [IDX_W-1:0]  restore_idx,
    output logic [DATA_W-1:0] restore_data,
    output logic [PC_W-1:0]   restore_pc,
    output logic              retry_pulse,
    output logic              spare_req,
    output logic              intermittent_flag
);
    import lsr_pkg::*;

    rec_state_e        state;
    logic              accept;
    logic              fin_commit;
    logic              fin_mis;
    logic [PC_W-1:0]   fin_pc;
    logic [IDX_W-1:0]  fin_wreg;
    logic [DATA_W-1:0] fin_wdata;
    logic              escalate;

    // Purpose: compare stage only admits results while no recovery runs.
    always_comb accept = (state == ST_IDLE);

    lsr_compare #(.PC_W(PC_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .accept(accept), .cmp_valid(cmp_valid),
        .a_pc(a_pc), .a_wreg(a_wreg), .a_wdata(a_wdata),
        .b_pc(b_pc), .b_wreg(b_wreg), .b_wdata(b_wdata),
        .fin_commit(fin_commit), .fin_mis(fin_mis),
        .fin_pc(fin_pc), .fin_wreg(fin_wreg), .fin_wdata(fin_wdata)
    );

    lsr_ckpt_store #(.PC_W(PC_W), .DATA_W(DATA_W), .NREGS(NREGS), .IDX_W(IDX_W)) u_ckpt (
        .clk(clk), .rst_n(rst_n), .wr_en(fin_commit), .wr_pc(fin_pc),
        .wr_idx(fin_wreg), .wr_data(fin_wdata), .rd_idx(restore_idx),
        .rd_data(restore_data), .ckpt_pc(restore_pc)
    );

    lsr_err_track #(.CNT_W(CNT_W)) u_err (
        .clk(clk), .rst_n(rst_n), .mis(fin_mis), .commit(fin_commit),
        .cfg_fail_limit(cfg_fail_limit), .cfg_retry_window(cfg_retry_window),
        .cfg_decay_period(cfg_decay_period), .cfg_intermit_thresh(cfg_intermit_thresh),
        .escalate(escalate), .intermittent_flag(intermittent_flag)
    );

    lsr_sequencer #(.NREGS(NREGS), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .mis(fin_mis), .escalate(escalate),
        .purge_done(purge_done), .state(state), .restore_idx(restore_idx),
        .pipe_rst(pipe_rst), .purge_req(purge_req), .restore_valid(restore_valid),
        .retry_pulse(retry_pulse), .spare_req(spare_req)
    );

    // Purpose: final-stage retire strobe to the pipelines.
    always_comb commit_en = fin_commit;

    // R6
    no_commit_in_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> !pipe_rst && !purge_req && !restore_valid && !retry_pulse);

    // R2
    mis_then_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_mis |=> pipe_rst && !commit_en);

    // R7
    halt_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spare_req |-> !commit_en && !restore_valid && !retry_pulse);

endmodule

// File: tb/lockstep_recovery_ctrl_test.sv
`timescale 1ns/1ps
module lockstep_recovery_ctrl_test;
    localparam int PC_W = 16, DATA_W = 32, NREGS = 8, CNT_W = 8, IDX_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CNT_W-1:0] cfg_fail_limit = 8'd3, cfg_retry_window = 8'd40;
    logic [CNT_W-1:0] cfg_decay_period = 8'd4, cfg_intermit_thresh = 8'd2;
    logic cmp_valid = 1'b0, purge_done = 1'b0;
    logic [PC_W-1:0] a_pc = '0, b_pc = '0;
    logic [IDX_W-1:0] a_wreg = '0, b_wreg = '0;
    logic [DATA_W-1:0] a_wdata = '0, b_wdata = '0;
    logic commit_en, pipe_rst, purge_req, restore_valid, retry_pulse, spare_req, intermittent_flag;
    logic [IDX_W-1:0] restore_idx;
    logic [DATA_W-1:0] restore_data;
    logic [PC_W-1:0] restore_pc;

    always #4 clk = ~clk;

    lockstep_recovery_ctrl #(.PC_W(PC_W), .DATA_W(DATA_W), .NREGS(NREGS), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_fail_limit(cfg_fail_limit),
        .cfg_retry_window(cfg_retry_window), .cfg_decay_period(cfg_decay_period),
        .cfg_intermit_thresh(cfg_intermit_thresh), .cmp_valid(cmp_valid),
        .a_pc(a_pc), .a_wreg(a_wreg), .a_wdata(a_wdata),
        .b_pc(b_pc), .b_wreg(b_wreg), .b_wdata(b_wdata),
        .purge_done(purge_done), .commit_en(commit_en), .pipe_rst(pipe_rst),
        .purge_req(purge_req), .restore_valid(restore_valid), .restore_idx(restore_idx),
        .restore_data(restore_data), .restore_pc(restore_pc), .retry_pulse(retry_pulse),
        .spare_req(spare_req), .intermittent_flag(intermittent_flag)
    );

    int n_chk = 0, n_fail = 0;
    logic [DATA_W-1:0] mreg [NREGS];
    logic [PC_W-1:0] mpc = '0;
    logic [IDX_W+DATA_W+PC_W-1:0] expq [$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the expected restore beats as the design produces them (R4).
    always @(negedge clk) begin
        if (rst_n && restore_valid) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R4", "unexpected restore beat", 64'(restore_idx), 64'hffff);
            end else begin
                logic [IDX_W+DATA_W+PC_W-1:0] e;
                e = expq.pop_front();
                chk({restore_idx, restore_data, restore_pc} == e, "R4", "restore beat",
                    64'({restore_idx, restore_data, restore_pc}), 64'(e));
            end
        end
    end

    // Driver: one result at the compare stage; corrupt flips copy-B data bits.
    task automatic op(input logic [PC_W-1:0] pc, input logic [IDX_W-1:0] r,
                      input logic [DATA_W-1:0] d, input logic [DATA_W-1:0] corrupt,
                      input bit expect_restore, input bit check_commit);
        @(negedge clk);
        cmp_valid = 1'b1; a_pc = pc; b_pc = pc; a_wreg = r; b_wreg = r;
        a_wdata = d; b_wdata = d ^ corrupt;
        @(negedge clk);
        cmp_valid = 1'b0;
        if (corrupt == '0) begin
            mreg[r] = d; mpc = pc;
            if (check_commit) chk(commit_en == 1'b1, "R1", "commit_en after match", 64'(commit_en), 64'd1);
        end else begin
            chk(commit_en == 1'b0, "R2", "no commit on mismatch", 64'(commit_en), 64'd0);
            if (expect_restore)
                for (int i = 0; i < NREGS; i++) expq.push_back({IDX_W'(i), mreg[i], mpc});
        end
    endtask

    // Services one recovery; optionally injects results while the purge is pending.
    task automatic recover(input bit inject);
        @(negedge clk);
        chk(pipe_rst == 1'b1 && spare_req == 1'b0, "R2", "pipe_rst after mismatch", 64'(pipe_rst), 64'd1);
        @(negedge clk);
        chk(pipe_rst == 1'b0 && purge_req == 1'b1, "R3", "purge_req after reset", 64'({pipe_rst, purge_req}), 64'd1);
        for (int i = 0; i < 3; i++) begin
            if (inject && i == 0) begin
                cmp_valid = 1'b1; a_pc = 16'hdead; b_pc = 16'hdead; a_wreg = 3'd1; b_wreg = 3'd1;
                a_wdata = 32'h11; b_wdata = 32'h22;
            end else if (inject && i == 1) begin
                b_wdata = 32'h11;
            end else begin
                cmp_valid = 1'b0;
            end
            @(negedge clk);
            chk(purge_req == 1'b1 && commit_en == 1'b0, "R3", "purge_req held without done", 64'(purge_req), 64'd1);
        end
        cmp_valid = 1'b0;
        purge_done = 1'b1;
        @(negedge clk);
        purge_done = 1'b0;
        for (int i = 0; i < NREGS; i++) @(negedge clk);
        chk(retry_pulse == 1'b1, "R5", "retry after last restore beat", 64'(retry_pulse), 64'd1);
        chk(expq.size() == 0, "R4", "all restore beats seen", 64'(expq.size()), 64'd0);
        @(negedge clk);
        chk(retry_pulse == 1'b0 && pipe_rst == 1'b0, "R5", "retry single cycle", 64'(retry_pulse), 64'd0);
    endtask

    bit done = 1'b0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R9", "watchdog expired", 64'd0, 64'd1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREGS; i++) mreg[i] = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk({commit_en, pipe_rst, purge_req, restore_valid, retry_pulse, spare_req, intermittent_flag} == 7'd0,
            "R9", "outputs in reset", 64'({commit_en, pipe_rst, purge_req, restore_valid, retry_pulse, spare_req}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(restore_pc == '0 && restore_data == '0, "R9", "checkpoint cleared", 64'(restore_pc), 64'd0);

        // R1: several agreed results with distinct registers and patterns
        for (int i = 0; i < NREGS; i++)
            op(16'h100 + 16'(i * 4), IDX_W'(i), 32'hA5000000 | 32'(i * 32'h111), '0, 1'b0, 1'b1);
        op(16'h140, 3'd3, 32'hCAFEF00D, '0, 1'b0, 1'b1);
        @(negedge clk);
        chk(commit_en == 1'b0, "R1", "commit_en single cycle", 64'(commit_en), 64'd0);

        // R2/R4: failing write to r3 must not appear in the restore
        op(16'h144, 3'd3, 32'h0BADBEEF, 32'h00000100, 1'b1, 1'b0);
        recover(1'b0);
        chk(intermittent_flag == 1'b0, "R8", "flag below threshold", 64'(intermittent_flag), 64'd0);
        op(16'h148, 3'd5, 32'h5555AAAA, '0, 1'b0, 1'b1);

        // R7/R6: mismatch inside the window, with ignored results during purge
        op(16'h14C, 3'd0, 32'h1, 32'h1, 1'b1, 1'b0);
        recover(1'b1);
        chk(intermittent_flag == 1'b1, "R8", "flag at threshold", 64'(intermittent_flag), 64'd1);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(pipe_rst == 1'b0 && commit_en == 1'b0, "R6", "ignored result caused no action", 64'(pipe_rst), 64'd0);
        end

        // R7: mismatch outside the window restarts the count, so no halt
        repeat (60) @(negedge clk);
        op(16'h150, 3'd2, 32'h2, 32'h80000000, 1'b1, 1'b0);
        recover(1'b0);
        chk(spare_req == 1'b0, "R7", "no halt outside window", 64'(spare_req), 64'd0);

        // R8: decay after error-free commits (count 3 -> 2 -> 1)
        for (int i = 0; i < 4; i++) op(16'h200 + 16'(i), IDX_W'(i), 32'h3000 + 32'(i), '0, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        chk(intermittent_flag == 1'b1, "R8", "flag after one decay", 64'(intermittent_flag), 64'd1);
        for (int i = 0; i < 4; i++) op(16'h210 + 16'(i), IDX_W'(i + 4), 32'h4000 + 32'(i), '0, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        chk(intermittent_flag == 1'b0, "R8", "flag cleared after two decays", 64'(intermittent_flag), 64'd0);

        // R7: three mismatches in a row escalate to the spare request
        repeat (60) @(negedge clk);
        op(16'h300, 3'd6, 32'h6, 32'h6, 1'b1, 1'b0);
        recover(1'b0);
        op(16'h304, 3'd6, 32'h7, 32'h1, 1'b1, 1'b0);
        recover(1'b0);
        op(16'h308, 3'd6, 32'h8, 32'h2, 1'b0, 1'b0);
        @(negedge clk);
        chk(spare_req == 1'b1 && pipe_rst == 1'b1, "R7", "halt with spare request", 64'({spare_req, pipe_rst}), 64'h3);
        op(16'h30C, 3'd1, 32'h9, '0, 1'b0, 1'b0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(spare_req && pipe_rst && !commit_en && !restore_valid && !retry_pulse,
                "R7", "halt is terminal", 64'({spare_req, commit_en, restore_valid}), 64'h4);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule